// File: doc/BRIEF.md
# Headphone-Sense Output Mode Controller

This block chooses how a stereo amplifier drives its outputs. Its two choices are a bridged speaker mode and a single-ended headphone mode. It also chooses which external gain network is active, and it produces the mute and input-source controls.

The headphone-sense pin is treated as a logic level. It is synchronized through a flop chain and then debounced by a hold counter. Only after that can it steer the mode.

The configuration bits come from a register file elsewhere on the chip. One of them disables automatic sensing, so software can pick the mode and the gain network directly. Every debounced change of the sense level raises a host interrupt. The interrupt stays set until the host signals a read of the status register. A shutdown bit parks the block in a muted, powered-down configuration.

All control outputs are registered. A configuration change appears on the outputs one clock later. A sense-pin change appears on the outputs after the synchronizer and the full hold window.

Top module: `hp_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, every output is 0.
- R2: With `cfg_sense_off`=0 and the debounced sense level low, `mode_se`=0 (bridged speaker) and `gain_b`=0 (gain network A).
- R3: With `cfg_sense_off`=0 and the debounced sense level high, `mode_se`=1 (single-ended headphone) and `gain_b`=1 (gain network B).
- R4: With `cfg_sense_off`=1, the sense pin has no effect on the mode. `mode_se` copies `cfg_hp_sel` (0 = bridged, 1 = single-ended) and `gain_b` copies `cfg_gain_b` (0 = A, 1 = B), one clock after the inputs.
- R5: `spk_mute` is 1 whenever `mode_se` is 1, and it is 0 in bridged mode outside shutdown.
- R6: `mute_l` and `mute_r` follow `cfg_mute_l` and `cfg_mute_r` independently, one clock later.
- R7: `src_sel` follows `cfg_src_sel` (0 = input set 1, 1 = input set 2), one clock later.
- R8: While `cfg_shutdown`=1, the next clock drives `pwr_down`, `spk_mute`, `mute_l` and `mute_r` to 1, and `mode_se`, `gain_b` and `src_sel` to 0.
- R9: A sense-pin level reaches `sense_level` and the mode only after it has been stable for `DEB_CYCLES` clocks (default 1024) behind a two-flop synchronizer. A shorter pulse changes nothing.
- R10: Each change of the debounced sense level, in either direction, sets `irq`. `irq` then holds until a cycle with `stat_rd`=1 clears it.
- R11: `sense_level` reports the debounced sense level whatever the state of `cfg_sense_off` or `cfg_shutdown`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_raw | input | 1 | Headphone-sense pin level, asynchronous |
| cfg_sense_off | input | 1 | 1 = ignore the sense pin and use the register mode bits |
| cfg_hp_sel | input | 1 | Register mode: 0 bridged speaker, 1 single-ended headphone |
| cfg_gain_b | input | 1 | Register gain path: 0 network A, 1 network B |
| cfg_mute_l | input | 1 | Left channel mute request |
| cfg_mute_r | input | 1 | Right channel mute request |
| cfg_src_sel | input | 1 | Input source: 0 set 1, 1 set 2 |
| cfg_shutdown | input | 1 | Power-down request |
| stat_rd | input | 1 | Status register read strobe; clears the interrupt |
| mode_se | output | 1 | 1 = single-ended headphone mode, 0 = bridged speaker mode |
| gain_b | output | 1 | 1 = gain network B, 0 = network A |
| spk_mute | output | 1 | Speaker amplifier mute |
| mute_l | output | 1 | Left channel mute |
| mute_r | output | 1 | Right channel mute |
| src_sel | output | 1 | Input source select |
| pwr_down | output | 1 | Powered-down state |
| sense_level | output | 1 | Debounced sense level |
| irq | output | 1 | Host interrupt, sticky until read |

## Verification
A debounce counter that resets at the wrong time, or that compares against the wrong limit, shows up as a mode flip that comes too early or too late around the `DEB_CYCLES` boundary. A bad counter can also let a short glitch through to `sense_level` and `irq`. A wrong interrupt flop shows as `irq` missing after a debounced edge, or dropping before the read strobe. Both checks need one hold window of about a thousand clocks. A wrong decode path shows on the very next clock after a configuration change: the mode, gain, mute or source output disagrees with the register bits or with the shutdown forcing.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    typedef struct packed {
        logic pwr_down;
        logic mode_se;
        logic gain_b;
        logic spk_mute;
        logic mute_l;
        logic mute_r;
        logic src_sel;
    } ctl_out_t;

    localparam ctl_out_t CTL_RESET = '0;

    typedef struct packed {
        logic     irq;
        ctl_out_t ctl;
    } top_state_t;

endpackage

// File: rtl/hpm_sync.sv
module hpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hpm_debounce.sv
module hpm_debounce #(
    parameter int HOLD = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_sync,
    output logic level,
    output logic flip
);
    localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] cnt;
    } deb_t;

    deb_t st_d, st_q;
    logic differs, at_limit;

    always_comb begin
        st_d     = st_q;
        differs  = (in_sync != st_q.level);
        at_limit = (st_q.cnt == LAST);
        if (!differs) begin
            st_d.cnt = '0;
        end else if (at_limit) begin
            st_d.level = in_sync;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
    assign flip  = differs && at_limit;
endmodule

// File: rtl/hpm_decode.sv
module hpm_decode
    import hpm_pkg::*;
(
    input  logic     level,
    input  logic     cfg_sense_off,
    input  logic     cfg_hp_sel,
    input  logic     cfg_gain_b,
    input  logic     cfg_mute_l,
    input  logic     cfg_mute_r,
    input  logic     cfg_src_sel,
    input  logic     cfg_shutdown,
    output ctl_out_t ctl
);
    logic sel_se, sel_b;

    always_comb begin
        sel_se = cfg_sense_off ? cfg_hp_sel : level;
        sel_b  = cfg_sense_off ? cfg_gain_b : level;
        ctl    = CTL_RESET;
        if (cfg_shutdown) begin
            ctl.pwr_down = 1'b1;
            ctl.spk_mute = 1'b1;
            ctl.mute_l   = 1'b1;
            ctl.mute_r   = 1'b1;
        end else begin
            ctl.mode_se  = sel_se;
            ctl.gain_b   = sel_b;
            ctl.spk_mute = sel_se;
            ctl.mute_l   = cfg_mute_l;
            ctl.mute_r   = cfg_mute_r;
            ctl.src_sel  = cfg_src_sel;
        end
    end
endmodule

// File: rtl/hp_mode_ctrl.sv
module hp_mode_ctrl
    import hpm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_raw,
    input  logic cfg_sense_off,
    input  logic cfg_hp_sel,
    input  logic cfg_gain_b,
    input  logic cfg_mute_l,
    input  logic cfg_mute_r,
    input  logic cfg_src_sel,
    input  logic cfg_shutdown,
    input  logic stat_rd,
    output logic mode_se,
    output logic gain_b,
    output logic spk_mute,
    output logic mute_l,
    output logic mute_r,
    output logic src_sel,
    output logic pwr_down,
    output logic sense_level,
    output logic irq
);
    logic       sense_sync;
    logic       deb_level;
    logic       deb_flip;
    ctl_out_t   ctl_next;
    top_state_t st_d, st_q;

    hpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sense_raw),
        .q    (sense_sync)
    );

    hpm_debounce #(.HOLD(DEB_CYCLES)) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_sync(sense_sync),
        .level  (deb_level),
        .flip   (deb_flip)
    );

    hpm_decode u_dec (
        .level        (deb_level),
        .cfg_sense_off(cfg_sense_off),
        .cfg_hp_sel   (cfg_hp_sel),
        .cfg_gain_b   (cfg_gain_b),
        .cfg_mute_l   (cfg_mute_l),
        .cfg_mute_r   (cfg_mute_r),
        .cfg_src_sel  (cfg_src_sel),
        .cfg_shutdown (cfg_shutdown),
        .ctl          (ctl_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ctl = ctl_next;
        if (deb_flip)     st_d.irq = 1'b1;
        else if (stat_rd) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_se     = st_q.ctl.mode_se;
    assign gain_b      = st_q.ctl.gain_b;
    assign spk_mute    = st_q.ctl.spk_mute;
    assign mute_l      = st_q.ctl.mute_l;
    assign mute_r      = st_q.ctl.mute_r;
    assign src_sel     = st_q.ctl.src_sel;
    assign pwr_down    = st_q.ctl.pwr_down;
    assign sense_level = deb_level;
    assign irq         = st_q.irq;
endmodule

// File: rtl/hp_mode_ctrl_chk.sv
module hp_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_sense_off,
    input logic cfg_hp_sel,
    input logic cfg_gain_b,
    input logic cfg_shutdown,
    input logic stat_rd,
    input logic mode_se,
    input logic gain_b,
    input logic spk_mute,
    input logic mute_l,
    input logic mute_r,
    input logic src_sel,
    input logic pwr_down,
    input logic sense_level,
    input logic irq
);
    a_r5_se_mutes_spk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_se |-> spk_mute);

    a_r8_shutdown_forces: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shutdown |=> (pwr_down && spk_mute && mute_l && mute_r
                          && !mode_se && !gain_b && !src_sel));

    a_r4_override_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sense_off && !cfg_shutdown) |=>
            (mode_se == $past(cfg_hp_sel) && gain_b == $past(cfg_gain_b)));

    a_r2_auto_follows_sense: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sense_off && !cfg_shutdown) |=>
            (mode_se == $past(sense_level) && gain_b == $past(sense_level)));

    a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_rd) |=> irq);

    a_r10_irq_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (sense_level != $past(sense_level)));
endmodule

bind hp_mode_ctrl hp_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sense_off(cfg_sense_off),
    .cfg_hp_sel   (cfg_hp_sel),
    .cfg_gain_b   (cfg_gain_b),
    .cfg_shutdown (cfg_shutdown),
    .stat_rd      (stat_rd),
    .mode_se      (mode_se),
    .gain_b       (gain_b),
    .spk_mute     (spk_mute),
    .mute_l       (mute_l),
    .mute_r       (mute_r),
    .src_sel      (src_sel),
    .pwr_down     (pwr_down),
    .sense_level  (sense_level),
    .irq          (irq)
);

// File: tb/hp_mode_ctrl_bench.sv
module hp_mode_ctrl_bench;
    localparam int DEB = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sense_raw = 1'b0;
    logic cfg_sense_off = 1'b0, cfg_hp_sel = 1'b0, cfg_gain_b = 1'b0;
    logic cfg_mute_l = 1'b0, cfg_mute_r = 1'b0, cfg_src_sel = 1'b0;
    logic cfg_shutdown = 1'b0, stat_rd = 1'b0;
    logic mode_se, gain_b, spk_mute, mute_l, mute_r, src_sel, pwr_down;
    logic sense_level, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hp_mode_ctrl #(.DEB_CYCLES(DEB)) u_hp_mode_ctrl (.*);

    // stim: {shutdown, sense_off, hp_sel, gain_b, mute_l, mute_r, src}
    // exp : {pwr_down, mode_se, gain_b, spk_mute, mute_l, mute_r, src_sel}
    localparam int NV = 10;
    localparam logic [6:0] STIM [NV] = '{
        7'b0000000, 7'b0000100, 7'b0000010, 7'b0000001, 7'b0111000,
        7'b0101000, 7'b0110000, 7'b1111111, 7'b1000000, 7'b0100111};
    localparam logic [6:0] EXPV [NV] = '{
        7'b0000000, 7'b0000100, 7'b0000010, 7'b0000001, 7'b0111000,
        7'b0010000, 7'b0101000, 7'b1001110, 7'b1001110, 7'b0000111};
    localparam string TAGV [NV] = '{
        "R2", "R6", "R6", "R7", "R4 R5", "R4", "R4 R5", "R8", "R8", "R6 R7"};

    function automatic logic [6:0] outs();
        return {pwr_down, mode_se, gain_b, spk_mute, mute_l, mute_r, src_sel};
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic apply(input logic [6:0] s);
        {cfg_shutdown, cfg_sense_off, cfg_hp_sel, cfg_gain_b,
         cfg_mute_l, cfg_mute_r, cfg_src_sel} = s;
    endtask

    task automatic read_status();
        stat_rd = 1'b1;
        cycles(1);
        stat_rd = 1'b0;
    endtask

    initial begin
        cycles(3);
        check("R1 reset", {outs(), sense_level, irq}, 9'b0);
        rst_n = 1'b1;
        cycles(1);
        check("R1 after release", {outs(), sense_level, irq}, 9'b0);

        for (int v = 0; v < NV; v++) begin
            apply(STIM[v]);
            cycles(1);
            check(TAGV[v], outs(), EXPV[v]);
        end

        // override on, sense goes high: mode unaffected, level and irq follow
        apply(7'b0100000);
        sense_raw = 1'b1;
        cycles(DEB + 6);
        check("R4 sense ignored", outs(), 7'b0000000);
        check("R11 level under override", {6'b0, sense_level}, 7'd1);
        check("R10 irq on rise", {6'b0, irq}, 7'd1);
        read_status();
        check("R10 read clears", {6'b0, irq}, 7'd0);

        // automatic mode with sense high
        apply(7'b0000000);
        cycles(1);
        check("R3 R5 headphone", outs(), 7'b0111000);

        // glitch shorter than the hold window
        sense_raw = 1'b0;
        cycles(100);
        sense_raw = 1'b1;
        cycles(DEB + 6);
        check("R9 glitch mode", outs(), 7'b0111000);
        check("R9 glitch irq", {6'b0, irq}, 7'd0);

        // real removal: not yet at DEB cycles, done after window
        sense_raw = 1'b0;
        cycles(DEB);
        check("R9 before window", outs(), 7'b0111000);
        cycles(6);
        check("R2 after removal", outs(), 7'b0000000);
        check("R10 irq on fall", {6'b0, irq}, 7'd1);
        cycles(50);
        check("R10 irq holds", {6'b0, irq}, 7'd1);
        read_status();
        check("R10 cleared", {6'b0, irq}, 7'd0);

        // shutdown with headphone present
        sense_raw = 1'b1;
        apply(7'b1000001);
        cycles(DEB + 6);
        check("R8 shutdown holds mode", outs(), 7'b1001110);
        check("R11 level in shutdown", {6'b0, sense_level}, 7'd1);
        apply(7'b0000000);
        cycles(1);
        check("R3 leave shutdown", outs(), 7'b0111000);

        // reset mid-operation
        rst_n = 1'b0;
        cycles(1);
        check("R1 reset again", {outs(), irq}, 8'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule